// File: doc/BRIEF.md
# Oscillator Power-Down Clock Sequencer

This block holds a two-field power-control register. One field selects the slow ring clock instead of the fast oscillator clock. The other field powers the oscillator down. The block turns these fields into a registered clock-source select and an oscillator power-down output. It enforces the order in which software may enter and leave the oscillator-off state. Writes that break that order are refused and latch an error bit.

The way back to the fast clock is timed by a loadable down-counter that models the oscillator start-up wait. Software clears the power-down field, loads the counter, and waits for the expired flag. It may watch the flag by interrupt or by polling. Only then is it allowed to drop the slow-clock select. If the oscillator is powered down while the fast clock is still selected, the core clock stops, and only a reset brings it back.

An active-low reset pin clears the power-down field asynchronously as soon as it falls. The rest of the control state is held in reset until two reference-clock cycles after the pin rises. The block also measures how long the pin was low against a minimum time given in microseconds and a reference frequency. A pulse that is too short sets a flag. Only the synchronous reset clears that flag.

Top module: `osc_pd_seq`

## Requirements
- R1: A write with `wr_en` takes `wr_data[0]` as the slow-clock select and `wr_data[1]` as the oscillator-off field. An accepted write shows in `rd_data` after the clock edge. The `rd_data` bits are: 0 slow select, 1 oscillator off, 2 sticky error, 3 active clock source (1 = slow), 4 counter expired, 5 short reset pulse, 6 core halted, 7 zero.
- R2: `clk_sel_slow` (and `rd_data[3]`) take the slow-select field value one clock after the field changes, never in the same cycle.
- R3: A write that sets the oscillator-off field while keeping slow selected is refused, and sets the sticky error bit, in two cases. The first is when slow was not already selected. The second is when fewer than two write-free cycles lie between the write that set slow and this write. A write on the third cycle after is accepted.
- R4: Setting the oscillator-off field with the slow select at 0 stops the core (`core_halt` = 1). While halted, register writes and counter loads are ignored until a reset.
- R5: A write that clears the slow select is refused, and sets the sticky error bit, in two cases. The first is while the oscillator-off field is 1. The second is after a power-down, until the start-up counter has expired.
- R6: `cnt_load` loads `cnt_load_val`. The counter then decrements once per cycle, only while the oscillator-off field is 0. `cnt_expired` is 1 while the count is zero after a load. Setting the oscillator-off field disarms it.
- R7: A falling edge on `pin_rst_n` forces `osc_pd` to 0 at once, without waiting for a clock.
- R8: `core_rst_hold` is 1 while the pin is low and for two clock edges after it rises. During that time the slow select, the error bit and the halt state are cleared.
- R9: If the pin stays low for fewer than `MIN_RST_US*REF_CLK_MHZ` clocks (4000 by default), `rd_data[5]` is set. Only `rst` clears it.
- R10: After `rst`, every output and every status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| pin_rst_n | input | 1 | External active-low reset pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Write data: bit 0 slow select, bit 1 oscillator off |
| cnt_load | input | 1 | Load the start-up counter |
| cnt_load_val | input | CNT_W | Start-up count in cycles |
| rd_data | output | 8 | Status and field read-back |
| clk_sel_slow | output | 1 | Clock mux select, 1 = slow source |
| osc_pd | output | 1 | Oscillator power-down |
| core_halt | output | 1 | Core clock stopped |
| core_rst_hold | output | 1 | Core held in reset from the pin |
| cnt_expired | output | 1 | Start-up counter reached zero |

## Verification
Two events can land in the same cycle: the start-up counter reaching zero, and a write that clears the slow select. The bench drives that write on the exact edge where the count steps from one to zero, where it must be refused. It then drives the same write one edge later, where it must be accepted. A reference model in the bench tracks counter, gap and field state through directed sequences and a long seeded random mix of writes and loads. Every status bit is compared against that model each cycle.

// File: rtl/osc_pd_pkg.sv
package osc_pd_pkg;

    localparam int STAT_W = 8;
    localparam logic [1:0] GAP_MIN = 2'd2;

    typedef struct packed {
        logic osc_off;
        logic slow_sel;
    } pwr_fields_t;

    typedef enum logic [1:0] {
        WR_OK      = 2'd0,
        WR_REJ_CLR = 2'd1,
        WR_REJ_SET = 2'd2
    } wr_verdict_t;

    typedef struct packed {
        logic        halt;
        logic        short_rst;
        logic        expired;
        logic        clk_sel;
        logic        err;
        pwr_fields_t f;
    } status_t;

    function automatic wr_verdict_t judge(
        input pwr_fields_t cur,
        input pwr_fields_t nxt,
        input logic [1:0]  gap,
        input logic        stale,
        input logic        expired
    );
        if (cur.slow_sel && !nxt.slow_sel && (cur.osc_off || (stale && !expired)))
            return WR_REJ_CLR;
        if (!cur.osc_off && nxt.osc_off && nxt.slow_sel && (!cur.slow_sel || gap < GAP_MIN))
            return WR_REJ_SET;
        return WR_OK;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input status_t s);
        return {1'b0, s};
    endfunction

endpackage

// File: rtl/osc_pd_rst_mon.sv
module osc_pd_rst_mon #(
    parameter int MIN_LOW = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_rst_n,
    output logic core_rst_hold,
    output logic short_rst
);
    localparam int LW = $clog2(MIN_LOW + 2);

    logic          s1, s2;
    logic [LW-1:0] low_cnt;

    assign core_rst_hold = !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= 1'b1;
            s2        <= 1'b1;
            low_cnt   <= '0;
            short_rst <= 1'b0;
        end else begin
            s1 <= pin_rst_n;
            s2 <= s1;
            if (!s2) begin
                if (low_cnt != LW'(MIN_LOW))
                    low_cnt <= low_cnt + LW'(1);
            end else begin
                low_cnt <= '0;
            end
            if (!s2 && s1 && (low_cnt < LW'(MIN_LOW - 1)))
                short_rst <= 1'b1;
        end
    end

endmodule

// File: rtl/osc_pd_timer.sv
module osc_pd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             osc_off,
    input  logic             off_set,
    output logic             expired,
    output logic             stale
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    assign expired = armed && (cnt == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt   <= '0;
            armed <= 1'b0;
            stale <= 1'b0;
        end else begin
            if (off_set) begin
                armed <= 1'b0;
            end else if (load) begin
                cnt   <= load_val;
                armed <= 1'b1;
            end else if (!osc_off && cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (off_set)
                stale <= 1'b1;
            else if (expired)
                stale <= 1'b0;
        end
    end

endmodule

// File: rtl/osc_pd_ctl.sv
module osc_pd_ctl
    import osc_pd_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  logic        pin_rst_n,
    input  logic        wr_en,
    input  pwr_fields_t wr_fields,
    input  logic        expired,
    input  logic        stale,
    output pwr_fields_t fields,
    output logic        clk_sel,
    output logic        err,
    output logic        halt,
    output logic        off_set
);
    logic        osc_off_q, slow_q;
    logic [1:0]  gap;
    logic        wr_live, acc;
    wr_verdict_t verdict;

    assign fields  = '{osc_off: osc_off_q, slow_sel: slow_q};
    assign verdict = judge(fields, wr_fields, gap, stale, expired);
    assign wr_live = wr_en && !halt;
    assign acc     = wr_live && (verdict == WR_OK);
    assign off_set = acc && !osc_off_q && wr_fields.osc_off;

    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n)
            osc_off_q <= 1'b0;
        else if (clr)
            osc_off_q <= 1'b0;
        else if (acc)
            osc_off_q <= wr_fields.osc_off;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            slow_q  <= 1'b0;
            gap     <= 2'd0;
            clk_sel <= 1'b0;
            err     <= 1'b0;
            halt    <= 1'b0;
        end else begin
            if (acc)
                slow_q <= wr_fields.slow_sel;
            if (acc && !slow_q && wr_fields.slow_sel)
                gap <= 2'd0;
            else if (gap != 2'd3)
                gap <= gap + 2'd1;
            clk_sel <= slow_q;
            if (wr_live && verdict != WR_OK)
                err <= 1'b1;
            if (off_set && !wr_fields.slow_sel)
                halt <= 1'b1;
        end
    end

endmodule

// File: rtl/osc_pd_seq.sv
module osc_pd_seq
    import osc_pd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int REF_CLK_MHZ = 200,
    parameter int MIN_RST_US  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_load_val,
    output logic [STAT_W-1:0] rd_data,
    output logic              clk_sel_slow,
    output logic              osc_pd,
    output logic              core_halt,
    output logic              core_rst_hold,
    output logic              cnt_expired
);
    localparam int MIN_LOW_CYC = REF_CLK_MHZ * MIN_RST_US;

    logic        clr, short_rst, err, stale, off_set;
    pwr_fields_t fields;
    status_t     st;

    assign clr = rst || core_rst_hold;

    osc_pd_rst_mon #(.MIN_LOW(MIN_LOW_CYC)) u_mon (
        .clk           (clk),
        .rst           (rst),
        .pin_rst_n     (pin_rst_n),
        .core_rst_hold (core_rst_hold),
        .short_rst     (short_rst)
    );

    osc_pd_ctl u_ctl (
        .clk       (clk),
        .clr       (clr),
        .pin_rst_n (pin_rst_n),
        .wr_en     (wr_en),
        .wr_fields (pwr_fields_t'(wr_data)),
        .expired   (cnt_expired),
        .stale     (stale),
        .fields    (fields),
        .clk_sel   (clk_sel_slow),
        .err       (err),
        .halt      (core_halt),
        .off_set   (off_set)
    );

    osc_pd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .clr      (clr),
        .load     (cnt_load && !core_halt),
        .load_val (cnt_load_val),
        .osc_off  (fields.osc_off),
        .off_set  (off_set),
        .expired  (cnt_expired),
        .stale    (stale)
    );

    assign osc_pd = fields.osc_off;

    always_comb begin
        st.halt      = core_halt;
        st.short_rst = short_rst;
        st.expired   = cnt_expired;
        st.clk_sel   = clk_sel_slow;
        st.err       = err;
        st.f         = fields;
        rd_data      = pack_status(st);
    end

endmodule

// File: rtl/osc_pd_seq_chk.sv
module osc_pd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       pin_rst_n,
    input logic       wr_en,
    input logic       cnt_load,
    input logic [7:0] rd_data,
    input logic       clk_sel_slow,
    input logic       osc_pd,
    input logic       core_halt,
    input logic       core_rst_hold,
    input logic       cnt_expired
);
    // R2: select output follows the field one cycle later
    p_sel_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(core_rst_hold)) |-> (clk_sel_slow == $past(rd_data[0])));

    // R3: oscillator-off rises only with slow held for three cycles, or as a halt
    p_off_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_pd) |-> (core_halt || $past(rd_data[0], 3)));

    // R3 / R5: error bit is sticky outside reset
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2] && !core_rst_hold) |=> rd_data[2]);

    // R4: halt persists until reset
    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (core_halt && !core_rst_hold) |=> core_halt);

    // R5: slow select never drops while the oscillator is off
    p_slow_clr_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_data[0]) && !$past(rst) && !$past(core_rst_hold)) |-> !$past(osc_pd));

    // R6: expired flag stays until a load or a write
    p_exp_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_expired && !cnt_load && !wr_en && !core_rst_hold) |=> cnt_expired);

    // R7: power-down is low whenever the pin is low
    p_pin_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !pin_rst_n |-> !osc_pd);

endmodule

bind osc_pd_seq osc_pd_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pin_rst_n     (pin_rst_n),
    .wr_en         (wr_en),
    .cnt_load      (cnt_load),
    .rd_data       (rd_data),
    .clk_sel_slow  (clk_sel_slow),
    .osc_pd        (osc_pd),
    .core_halt     (core_halt),
    .core_rst_hold (core_rst_hold),
    .cnt_expired   (cnt_expired)
);

// File: tb/osc_pd_seq_test.sv
`timescale 1ns/1ps
module osc_pd_seq_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_data = 2'b00;
    logic          cnt_load = 1'b0;
    logic [CW-1:0] cnt_load_val = '0;
    logic [7:0]    rd_data;
    logic          clk_sel_slow, osc_pd, core_halt, core_rst_hold, cnt_expired;

    int checks = 0;
    int fails  = 0;
    bit mdl_on = 0;

    logic m_slow, m_off, m_err, m_sel, m_halt, m_stale, m_armed;
    int   m_cnt, m_gap;

    always #2.5 clk = ~clk;

    osc_pd_seq uut (
        .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .rd_data(rd_data),
        .clk_sel_slow(clk_sel_slow), .osc_pd(osc_pd), .core_halt(core_halt),
        .core_rst_hold(core_rst_hold), .cnt_expired(cnt_expired)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic m_exp();
        return m_armed && (m_cnt == 0);
    endfunction

    function automatic logic [7:0] exp_rd();
        return {1'b0, m_halt, 1'b0, m_exp(), m_sel, m_err, m_off, m_slow};
    endfunction

    task automatic m_clear();
        m_slow = 0; m_off = 0; m_err = 0; m_sel = 0; m_halt = 0;
        m_stale = 0; m_armed = 0; m_cnt = 0; m_gap = 0;
    endtask

    task automatic m_step(input logic we, input logic [1:0] wd, input logic ld, input int lv);
        logic weg, ldg, ex, clr_s, set_o, rej_a, rej_b, acc, offs;
        weg   = we && !m_halt;
        ldg   = ld && !m_halt;
        ex    = m_exp();
        clr_s = m_slow && !wd[0];
        set_o = !m_off && wd[1];
        rej_a = clr_s && (m_off || (m_stale && !ex));
        rej_b = set_o && wd[0] && (!m_slow || m_gap < 2);
        acc   = weg && !rej_a && !rej_b;
        offs  = acc && set_o;
        if (offs) m_armed = 0;
        else if (ldg) begin m_cnt = lv; m_armed = 1; end
        else if (!m_off && m_cnt != 0) m_cnt--;
        if (offs) m_stale = 1; else if (ex) m_stale = 0;
        if (acc && !m_slow && wd[0]) m_gap = 0; else if (m_gap < 3) m_gap++;
        m_sel = m_slow;
        if (weg && (rej_a || rej_b)) m_err = 1;
        if (offs && !wd[0]) m_halt = 1;
        if (acc) begin m_slow = wd[0]; m_off = wd[1]; end
    endtask

    task automatic cyc(input logic we, input logic [1:0] wd, input logic ld = 0, input int lv = 0);
        @(negedge clk);
        if (mdl_on) begin
            chk("R1 status vs model", {24'b0, rd_data}, {24'b0, exp_rd()});
            chk("R6 outputs vs model", {28'b0, clk_sel_slow, osc_pd, core_halt, cnt_expired},
                {28'b0, m_sel, m_off, m_halt, m_exp()});
        end
        wr_en = we; wr_data = wd; cnt_load = ld; cnt_load_val = CW'(lv);
        if (mdl_on) m_step(we, wd, ld, lv);
    endtask

    task automatic do_rst();
        @(negedge clk);
        rst = 1; wr_en = 0; cnt_load = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_clear();
        m_step(0, 2'b00, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 got=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        m_clear();
        do_rst();
        mdl_on = 1;
        cyc(0, 2'b00);
        chk("R10 reset status", {24'b0, rd_data}, 32'h0);
        chk("R10 reset outputs", {28'b0, clk_sel_slow, osc_pd, core_halt, core_rst_hold}, 32'h0);

        // R1 / R2: field then select one cycle later
        cyc(1, 2'b01); cyc(0, 2'b00);
        chk("R1 slow field", rd_data[0], 1);
        chk("R2 select not yet", clk_sel_slow, 0);
        cyc(0, 2'b00);
        chk("R2 select follows", clk_sel_slow, 1);
        chk("R2 active source bit", rd_data[3], 1);

        // R3: too close (k=2)
        do_rst();
        cyc(1, 2'b01); cyc(0, 2'b00); cyc(1, 2'b11); cyc(0, 2'b00);
        chk("R3 reject k=2 off", osc_pd, 0);
        chk("R3 reject k=2 err", rd_data[2], 1);

        // R3: k=1 reject then k=3 accept
        do_rst();
        cyc(1, 2'b01); cyc(1, 2'b11); cyc(0, 2'b00);
        chk("R3 reject k=1", {30'b0, rd_data[2], osc_pd}, 32'h2);
        cyc(1, 2'b11); cyc(0, 2'b00);
        chk("R3 accept k=3", {30'b0, core_halt, osc_pd}, 32'h1);

        // R6 / R5: frozen count, ordered return
        cyc(0, 2'b00, 1, 4);
        repeat (6) cyc(0, 2'b00);
        chk("R6 frozen while off", cnt_expired, 0);
        cyc(1, 2'b10); cyc(0, 2'b00);
        chk("R5 clear slow while off", rd_data[0], 1);
        cyc(1, 2'b01);            // off cleared, edge W
        cyc(1, 2'b00);            // W+1 early
        cyc(0, 2'b00); cyc(0, 2'b00);
        cyc(1, 2'b00);            // W+4, count just reached zero
        cyc(1, 2'b00);            // W+5
        chk("R5 clear at zero edge refused", rd_data[0], 1);
        chk("R6 expired", cnt_expired, 1);
        cyc(0, 2'b00);
        chk("R5 clear after expiry", rd_data[0], 0);
        cyc(0, 2'b00);
        chk("R2 back to fast", clk_sel_slow, 0);

        // R4: halt
        do_rst();
        cyc(1, 2'b10); cyc(0, 2'b00);
        chk("R4 halt", {30'b0, core_halt, osc_pd}, 32'h3);
        cyc(1, 2'b01); cyc(0, 2'b00, 1, 0); cyc(0, 2'b00); cyc(0, 2'b00);
        chk("R4 write ignored", rd_data[0], 0);
        chk("R4 load ignored", cnt_expired, 0);

        // random mix
        do_rst();
        for (int i = 0; i < 3000; i++) begin
            if (m_halt) do_rst();
            cyc(($urandom % 3) == 0, 2'($urandom % 4), ($urandom % 10) == 0, int'($urandom % 8));
        end
        cyc(0, 2'b00);

        // pin tests
        mdl_on = 0;
        do_rst();
        cyc(1, 2'b01); repeat (3) cyc(0, 2'b00);
        cyc(1, 2'b11); cyc(0, 2'b00);
        chk("R7 setup off", osc_pd, 1);
        #1 pin_rst_n = 0;
        #1 chk("R7 async clear", osc_pd, 0);
        repeat (3) @(negedge clk);
        chk("R8 hold while low", core_rst_hold, 1);
        wr_en = 1; wr_data = 2'b01;
        @(negedge clk); wr_en = 0;
        repeat (2995) @(negedge clk);
        pin_rst_n = 1;
        @(negedge clk);
        chk("R8 hold one edge after rise", core_rst_hold, 1);
        @(negedge clk);
        chk("R8 released", core_rst_hold, 0);
        chk("R8 state cleared", {29'b0, rd_data[6], rd_data[2], rd_data[0]}, 32'h0);
        chk("R9 short pulse flag", rd_data[5], 1);
        do_rst();
        @(negedge clk);
        chk("R9 cleared by rst", rd_data[5], 0);
        pin_rst_n = 0;
        repeat (4200) @(negedge clk);
        pin_rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R9 long pulse no flag", rd_data[5], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule